// File: doc/BRIEF.md
# Outbound MMIO window partition decoder

This block sits on the outbound path of a host bridge. Each cycle it can take one CPU-side MMIO address. It reports which forwarding window claims the address, the PCIe address to issue, and the partition number that owns the access. The result appears two clock cycles later.

There are two kinds of window:

- **One low translating window.** It covers a naturally aligned power-of-two region of up to 4 GB. It keeps the address bits below its size and replaces the bits above its size with a programmed value, so the PCIe address is always 32-bit. It is split into 256 equal segments. A 256-entry table gives each segment its partition number.
- **Sixteen wide windows.** They forward the address unchanged. Each one supplies either one programmed partition number for its whole range (single mode), or the index of the segment hit, out of 256 equal segments (segmented mode).

When windows overlap, a fixed priority picks the winner. An address that no window claims is reported as a miss.

Window bases, sizes, modes and enables are held on configuration inputs, which are expected to be quasi-static. The segment table is loaded through a synchronous write port.

Top module: `mmio_window_decoder`

## Requirements
- R1: The low window claims an address when the address bits at and above the window's size exponent `lg` match the base. Base bits below `lg` are ignored. The PCIe address then carries CPU address bits [lg-1:0], bits lg..31 of `m32_upper`, and zeros in all bits at and above bit 32.
- R2: For a low-window hit, the segment index is CPU address bits [lg-1:lg-8]. The partition number is the table entry at that index. An entry is written by asserting `tbl_we` with `tbl_idx` and `tbl_pe` at a clock edge, and a later lookup returns the new value.
- R3: The low window takes part in decoding only while `m32_lg` lies in 8..32. Any other value makes it claim nothing.
- R4: On a wide-window hit, the PCIe address equals the CPU address unchanged.
- R5: A wide window in single mode (`w64_segmode` bit 0) reports its programmed `w64_pe` field for every address in its range.
- R6: A wide window in segmented mode (`w64_segmode` bit 1) reports CPU address bits [lg-1:lg-8] as the partition number.
- R7: A wide window takes part only while its `lg` lies in 28..ADDR_W. A smaller or larger exponent makes it claim nothing.
- R8: Overlaps are resolved as follows. The lowest-numbered claiming wide window wins. Any wide-window hit takes precedence over the low window.
- R9: An address that no window claims gives `out_miss`=1, with `out_pe`, `out_addr` and `out_win` all zero.
- R10: `out_win` reports the winner. Values 0..15 name the wide window of that number, and 16 names the low window. `out_valid` rises exactly two cycles after `req_valid`, and all result fields are valid in that same cycle.
- R11: While `rst` is high, and in the cycle after it, `out_valid` is 0.
- R12: A wide window whose enable bit is 0 claims nothing, whatever its base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address lookup request |
| req_addr | input | ADDR_W | CPU-side MMIO address |
| m32_en | input | 1 | Low window enable |
| m32_base | input | ADDR_W | Low window base |
| m32_lg | input | LG_W | Low window size exponent |
| m32_upper | input | 32 | Replacement value for bits above the low window size |
| w64_en | input | N_WIN64 | Wide window enables, one bit per window |
| w64_segmode | input | N_WIN64 | Wide window mode, 1 = segmented |
| w64_base | input | N_WIN64*ADDR_W | Wide window bases, window g at slice g |
| w64_lg | input | N_WIN64*LG_W | Wide window size exponents |
| w64_pe | input | N_WIN64*PE_W | Single-mode partition numbers |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_idx | input | 8 | Segment table write index |
| tbl_pe | input | PE_W | Segment table write data |
| out_valid | output | 1 | Result valid |
| out_miss | output | 1 | No window claimed the address |
| out_win | output | WIN_W | Winning window (16 = low window) |
| out_pe | output | PE_W | Partition number |
| out_addr | output | ADDR_W | PCIe address |

## Verification
The bench sweeps every one of the 256 segments, in both the table-mapped low window and a segmented wide window. This exposes a segment index taken from the wrong bit slice, which would show up as partition numbers that repeat or skip across the sweep.

It places a single-mode window inside a segmented one, and later enables a window that covers all of memory. A reversed or missing priority would then report the inner window, or let the low window win over a wide hit.

It also probes regions whose window is disabled, or has a size exponent out of range, along with a non-zero base offset below the window size and a rewritten table entry. A design that checked only the base, or ignored the legal size range, would claim these addresses where it should report a miss.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  localparam int SEG_W = 8;
  localparam int NSEG  = 1 << SEG_W;
  typedef logic [SEG_W-1:0] seg_idx_t;
endpackage

// File: rtl/mmio_win_match.sv
module mmio_win_match
  import mmio_dec_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LG_W   = 6,
  parameter int MIN_LG = 28,
  parameter int MAX_LG = 48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LG_W-1:0]   lg,
  input  logic              en,
  output logic              hit,
  output seg_idx_t          seg
);
  logic              legal;
  logic [ADDR_W-1:0] diff;
  logic              upper_eq;
  int                sh;

  always_comb begin
    legal    = en && (int'(lg) >= MIN_LG) && (int'(lg) <= MAX_LG);
    diff     = addr ^ base;
    upper_eq = 1'b1;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b >= int'(lg) && diff[b]) upper_eq = 1'b0;
    end
    hit = legal && upper_eq;
    sh  = int'(lg) - SEG_W;
    seg = '0;
    for (int s = 0; s < SEG_W; s++) begin
      if ((sh + s) >= 0 && (sh + s) < ADDR_W) seg[s] = addr[sh + s];
    end
  end
endmodule

// File: rtl/mmio_seg_table.sv
module mmio_seg_table
  import mmio_dec_pkg::*;
#(
  parameter int PE_W = 8
) (
  input  logic            clk,
  input  logic            we,
  input  seg_idx_t        wr_idx,
  input  logic [PE_W-1:0] wr_data,
  input  seg_idx_t        rd_idx,
  output logic [PE_W-1:0] rd_data
);
  logic [PE_W-1:0] mem [NSEG];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/mmio_prio_pick.sv
module mmio_prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mmio_dec_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int LG_W    = 6,
  parameter int PE_W    = 8,
  parameter int N_WIN64 = 16,
  parameter int M64_MIN_LG = 28,
  parameter int M32_MAX_LG = 32,
  parameter int WIN_W   = $clog2(N_WIN64 + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      m32_en,
  input  logic [ADDR_W-1:0]         m32_base,
  input  logic [LG_W-1:0]           m32_lg,
  input  logic [31:0]               m32_upper,
  input  logic [N_WIN64-1:0]        w64_en,
  input  logic [N_WIN64-1:0]        w64_segmode,
  input  logic [N_WIN64*ADDR_W-1:0] w64_base,
  input  logic [N_WIN64*LG_W-1:0]   w64_lg,
  input  logic [N_WIN64*PE_W-1:0]   w64_pe,
  input  logic                      tbl_we,
  input  logic [SEG_W-1:0]          tbl_idx,
  input  logic [PE_W-1:0]           tbl_pe,
  output logic                      out_valid,
  output logic                      out_miss,
  output logic [WIN_W-1:0]          out_win,
  output logic [PE_W-1:0]           out_pe,
  output logic [ADDR_W-1:0]         out_addr
);
  localparam int IDX_W = (N_WIN64 > 1) ? $clog2(N_WIN64) : 1;

  // ---- window compare ----
  logic [N_WIN64-1:0] hit64;
  seg_idx_t           seg64 [N_WIN64];
  logic               hit32;
  seg_idx_t           seg32;

  for (genvar g = 0; g < N_WIN64; g++) begin : g_w64
    mmio_win_match #(
      .ADDR_W(ADDR_W), .LG_W(LG_W), .MIN_LG(M64_MIN_LG), .MAX_LG(ADDR_W)
    ) u_match (
      .addr (req_addr),
      .base (w64_base[g*ADDR_W +: ADDR_W]),
      .lg   (w64_lg[g*LG_W +: LG_W]),
      .en   (w64_en[g]),
      .hit  (hit64[g]),
      .seg  (seg64[g])
    );
  end

  mmio_win_match #(
    .ADDR_W(ADDR_W), .LG_W(LG_W), .MIN_LG(SEG_W), .MAX_LG(M32_MAX_LG)
  ) u_m32_match (
    .addr (req_addr),
    .base (m32_base),
    .lg   (m32_lg),
    .en   (m32_en),
    .hit  (hit32),
    .seg  (seg32)
  );

  logic             found64;
  logic [IDX_W-1:0] win_idx;

  mmio_prio_pick #(.N(N_WIN64), .IDX_W(IDX_W)) u_pick (
    .req   (hit64),
    .found (found64),
    .idx   (win_idx)
  );

  // ---- low window translation ----
  logic [31:0] xlat32;
  always_comb begin
    for (int b = 0; b < 32; b++) begin
      xlat32[b] = (b < int'(m32_lg)) ? req_addr[b] : m32_upper[b];
    end
  end

  // ---- segment table (registered read, block RAM style) ----
  logic [PE_W-1:0] tbl_rd;
  mmio_seg_table #(.PE_W(PE_W)) u_table (
    .clk     (clk),
    .we      (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_pe),
    .rd_idx  (seg32),
    .rd_data (tbl_rd)
  );

  // ---- stage 1 ----
  logic              s1_valid;
  logic              s1_hit64;
  logic              s1_hit32;
  logic [IDX_W-1:0]  s1_idx;
  seg_idx_t          s1_seg;
  logic              s1_segmode;
  logic [PE_W-1:0]   s1_pe;
  logic [ADDR_W-1:0] s1_addr;
  logic [31:0]       s1_xlat;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
    s1_hit64   <= found64;
    s1_hit32   <= hit32;
    s1_idx     <= win_idx;
    s1_seg     <= seg64[win_idx];
    s1_segmode <= w64_segmode[win_idx];
    s1_pe      <= w64_pe[win_idx*PE_W +: PE_W];
    s1_addr    <= req_addr;
    s1_xlat    <= xlat32;
  end

  // ---- stage 2: registered outputs ----
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
    if (s1_hit64) begin
      out_miss <= 1'b0;
      out_win  <= WIN_W'(s1_idx);
      out_pe   <= s1_segmode ? PE_W'(s1_seg) : s1_pe;
      out_addr <= s1_addr;
    end else if (s1_hit32) begin
      out_miss <= 1'b0;
      out_win  <= WIN_W'(N_WIN64);
      out_pe   <= tbl_rd;
      out_addr <= ADDR_W'(s1_xlat);
    end else begin
      out_miss <= 1'b1;
      out_win  <= '0;
      out_pe   <= '0;
      out_addr <= '0;
    end
  end

  // ---- assertions ----
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 out_valid);
  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_miss && (out_win < N_WIN64)) |-> (out_addr == $past(req_addr, 2)));
  // R1
  low_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_miss && (out_win == N_WIN64)) |-> ((out_addr >> 32) == '0));
  // R9
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_miss) |-> (out_pe == '0 && out_addr == '0 && out_win == '0));
  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/test_mmio_window_decoder.sv
`timescale 1ns/1ps
module test_mmio_window_decoder;
  localparam int AW = 48;
  localparam int LW = 6;
  localparam int PW = 8;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr  = '0;
  logic            m32_en;
  logic [AW-1:0]   m32_base;
  logic [LW-1:0]   m32_lg;
  logic [31:0]     m32_upper;
  logic [NW-1:0]   w64_en, w64_segmode;
  logic [NW*AW-1:0] w64_base;
  logic [NW*LW-1:0] w64_lg;
  logic [NW*PW-1:0] w64_pe;
  logic            tbl_we = 1'b0;
  logic [7:0]      tbl_idx = '0;
  logic [PW-1:0]   tbl_pe = '0;
  logic            out_valid, out_miss;
  logic [4:0]      out_win;
  logic [PW-1:0]   out_pe;
  logic [AW-1:0]   out_addr;

  // bench-side configuration
  logic [AW-1:0] c_base [NW];
  int            c_lg   [NW];
  logic          c_en   [NW];
  logic          c_seg  [NW];
  logic [PW-1:0] c_pe   [NW];
  logic          c32_en;
  logic [AW-1:0] c32_base;
  int            c32_lg;
  logic [31:0]   c32_up;
  logic [PW-1:0] tbl_m [256];

  always_comb begin
    for (int g = 0; g < NW; g++) begin
      w64_base[g*AW +: AW] = c_base[g];
      w64_lg[g*LW +: LW]   = LW'(c_lg[g]);
      w64_en[g]            = c_en[g];
      w64_segmode[g]       = c_seg[g];
      w64_pe[g*PW +: PW]   = c_pe[g];
    end
    m32_en    = c32_en;
    m32_base  = c32_base;
    m32_lg    = LW'(c32_lg);
    m32_upper = c32_up;
  end

  mmio_window_decoder i_mmio_window_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .m32_en(m32_en), .m32_base(m32_base), .m32_lg(m32_lg), .m32_upper(m32_upper),
    .w64_en(w64_en), .w64_segmode(w64_segmode), .w64_base(w64_base),
    .w64_lg(w64_lg), .w64_pe(w64_pe), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_pe(tbl_pe), .out_valid(out_valid), .out_miss(out_miss),
    .out_win(out_win), .out_pe(out_pe), .out_addr(out_addr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // arithmetic reference
  task automatic model(input logic [AW-1:0] a, output logic m, output logic [4:0] w,
                       output logic [PW-1:0] p, output logic [AW-1:0] o);
    logic [63:0] msk;
    m = 1'b1; w = '0; p = '0; o = '0;
    for (int g = NW - 1; g >= 0; g--) begin
      if (c_en[g] && c_lg[g] >= 28 && c_lg[g] <= AW &&
          ((64'(a) >> c_lg[g]) == (64'(c_base[g]) >> c_lg[g]))) begin
        m = 1'b0; w = 5'(g); o = a;
        p = c_seg[g] ? PW'((64'(a) >> (c_lg[g] - 8)) & 64'hFF) : c_pe[g];
      end
    end
    if (m && c32_en && c32_lg >= 8 && c32_lg <= 32 &&
        ((64'(a) >> c32_lg) == (64'(c32_base) >> c32_lg))) begin
      m = 1'b0; w = 5'd16;
      p = tbl_m[(64'(a) >> (c32_lg - 8)) & 64'hFF];
      msk = (64'd1 << c32_lg) - 64'd1;
      o = AW'(((64'(c32_up) & ~msk) | (64'(a) & msk)) & 64'hFFFF_FFFF);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input string tag);
    logic em; logic [4:0] ew; logic [PW-1:0] ep; logic [AW-1:0] eo;
    model(a, em, ew, ep, eo);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || out_miss !== em || out_win !== ew ||
        out_pe !== ep || out_addr !== eo) begin
      errors++;
      $display("FAIL %s addr=%h actual v=%b miss=%b win=%0d pe=%h pa=%h expected v=1 miss=%b win=%0d pe=%h pa=%h",
               tag, a, out_valid, out_miss, out_win, out_pe, out_addr, em, ew, ep, eo);
    end
  endtask

  task automatic write_tbl(input int i, input logic [PW-1:0] v);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = 8'(i); tbl_pe = v; tbl_m[i] = v;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NW; g++) begin
      c_base[g] = '0; c_lg[g] = 28; c_en[g] = 1'b0; c_seg[g] = 1'b0; c_pe[g] = '0;
    end
    c32_en = 1'b1; c32_base = 48'h0000_8000_1234; c32_lg = 31; c32_up = 32'h9234_5678;
    c_base[0] = 48'h10_0000_0000; c_lg[0] = 32; c_en[0] = 1'b1; c_seg[0] = 1'b1;
    c_base[3] = 48'h10_4000_0000; c_lg[3] = 28; c_en[3] = 1'b1; c_pe[3] = 8'h5A;
    c_base[2] = 48'h20_0000_0000; c_lg[2] = 30; c_en[2] = 1'b1; c_pe[2] = 8'h3C;
    c_base[5] = 48'h30_0000_0000; c_lg[5] = 29; c_en[5] = 1'b0; c_pe[5] = 8'h11;
    c_base[9] = 48'h40_0000_0000; c_lg[9] = 27; c_en[9] = 1'b1; c_pe[9] = 8'h22;
    c_base[15] = '0; c_lg[15] = 48; c_seg[15] = 1'b1;

    repeat (3) @(negedge clk);
    checks++;  // R11 during reset
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R11 actual out_valid=%b expected 0", out_valid);
    end
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checks++;  // R11 after reset
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R11 actual out_valid=%b expected 0 after reset", out_valid);
    end

    for (int i = 0; i < 256; i++) write_tbl(i, PW'((i * 37 + 5) & 255));

    // R1 R2: every low-window segment, offset within segment varies
    for (int s = 0; s < 256; s++)
      issue(48'h8000_0000 + 48'(s) * 48'h80_0000 + 48'((s * 4099) & 32'h7F_FFFF), "R2");

    // R10: valid drops one cycle after the single request
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R10 actual out_valid=%b expected 0", out_valid);
    end

    // R6 R8: every segment of segmented window 0, includes inner window 3
    for (int s = 0; s < 256; s++)
      issue(48'h10_0000_0000 + 48'(s) * 48'h100_0000 + 48'(s * 13), "R6");
    issue(48'h10_4ABC_0000, "R8");

    // R4 R5: single mode
    issue(48'h20_0000_0000, "R5");
    issue(48'h20_3FFF_FFFC, "R5");
    issue(48'h20_1234_5678, "R4");

    // R12: disabled window, R7: undersized window, R9: plain misses
    issue(48'h30_0000_0100, "R12");
    issue(48'h40_0000_0100, "R7");
    issue(48'h00_7FFF_FFFF, "R9");
    issue(48'h01_0000_0000, "R9");
    issue(48'h20_4000_0000, "R9");

    // R2: rewrite one entry then look it up
    write_tbl(5, 8'hE7);
    issue(48'h8000_0000 + 48'd5 * 48'h80_0000 + 48'h10, "R2");

    // R3: low window out-of-range sizes
    c32_lg = 33; issue(48'h8000_0000, "R3");
    c32_lg = 7;  issue(48'h8000_0000, "R3");
    // R1: smaller low window, upper bits substituted
    c32_lg = 24; c32_base = 48'h0000_0300_0000;
    issue(48'h0000_03AB_CDEF, "R1");
    issue(48'h0000_0300_0000, "R1");
    c32_lg = 31; c32_base = 48'h0000_8000_0000;

    // R8: window covering all memory beats the low window but not window 2
    c_en[15] = 1'b1;
    for (int s = 0; s < 16; s++) issue(48'h8000_0000 + 48'(s) * 48'h800_0000, "R8");
    issue(48'h20_0000_0040, "R8");
    issue(48'h10_0100_0000, "R8");
    issue(48'hFF_0000_0000, "R6");
    // R7: upper legal bound disabled when exponent exceeds address width
    c_lg[15] = 49; issue(48'h01_0000_0000, "R7");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule